// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit is the bit-manipulation slice of an integer execute stage. It takes two operands of XLEN bits, a decoded operation code and a word-form flag, and returns one XLEN-bit result. It covers logic with an inverted operand, leading/trailing zero counts, population count, signed and unsigned minimum/maximum, sign and zero extension, rotations, a per-byte OR-combine and a byte-order reversal.

XLEN is a parameter of 32 or 64. With XLEN of 64, the word flag narrows the counting and rotating operations to the low 32 bits of their inputs and sign-extends their 32-bit result. For all other operations, and for any operation when XLEN is 32, the flag has no effect. The unit has no state. Register reads and any immediate operand come in on the operand ports. Decode, exceptions and pipelining are handled by the surrounding stage.

Top module: `bmu_exec`

## Requirements
- R1: Operation codes on `op_sel`: 0 AND-with-inverted-b, 1 OR-with-inverted-b, 2 XNOR. The result is a&~b, a|~b and ~(a^b) respectively.
- R2: Code 3 gives the count of leading zeros of a, and code 4 gives the count of trailing zeros of a. For an all-zero a, both give XLEN.
- R3: Code 5 gives the number of 1 bits in a.
- R4: Codes 6 and 7 give the signed minimum and signed maximum of a and b, treating both as two's complement.
- R5: Codes 8 and 9 give the unsigned minimum and unsigned maximum of a and b.
- R6: Code 10 sign-extends a[7:0]. Code 11 sign-extends a[15:0]. Code 12 zero-extends a[15:0].
- R7: Code 13 rotates a left and code 14 rotates a right. The rotate amount is b[log2(XLEN)-1:0], and the higher bits of b are ignored.
- R8: Code 15 sets each result byte to 0xFF if the matching byte of a has any 1 bit, and to 0x00 otherwise.
- R9: Code 16 reverses the byte order of a across all XLEN bits. Byte 0 goes to the top byte.
- R10: With XLEN of 64 and `word_mode`=1, codes 3, 4 and 5 operate on a[31:0] only. The count is sign-extended from bit 31. For a zero low word, the leading and trailing counts are 32.
- R11: With XLEN of 64 and `word_mode`=1, codes 13 and 14 rotate a[31:0] by b[4:0]. The 32-bit result is sign-extended to XLEN.
- R12: `word_mode` has no effect on codes other than 3, 4, 5, 13 and 14. Codes 17 to 31 give a zero result. No error is signalled in either case.
- R13: The result depends only on the present inputs, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Decoded operation code |
| word_mode | input | 1 | Select the 32-bit word form (XLEN of 64 only) |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Second operand, or the rotate amount |
| result | output | XLEN | Operation result |

## Verification
Every result is due in the same cycle as its inputs, because no register lies between the operand ports and `result`. The bench changes the inputs just after a rising edge and reads `result` at the following falling edge. Each comparison therefore sees settled logic and is independent of the clock edge. Expected values come from a model in the bench written in a different style, plus hand-worked constants for the corner cases.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    BM_ANDN  = 5'd0,
    BM_ORN   = 5'd1,
    BM_XNOR  = 5'd2,
    BM_CLZ   = 5'd3,
    BM_CTZ   = 5'd4,
    BM_CPOP  = 5'd5,
    BM_MIN   = 5'd6,
    BM_MAX   = 5'd7,
    BM_MINU  = 5'd8,
    BM_MAXU  = 5'd9,
    BM_SEXTB = 5'd10,
    BM_SEXTH = 5'd11,
    BM_ZEXTH = 5'd12,
    BM_ROL   = 5'd13,
    BM_ROR   = 5'd14,
    BM_ORCB  = 5'd15,
    BM_REV8  = 5'd16
  } bmu_op_e;

  // Operations that have a 32-bit word form
  function automatic logic has_word_form(input bmu_op_e op);
    return (op == BM_CLZ) || (op == BM_CTZ) || (op == BM_CPOP) ||
           (op == BM_ROL) || (op == BM_ROR);
  endfunction
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int W  = 64,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] lead_zeros,
  output logic [CW-1:0] trail_zeros,
  output logic [CW-1:0] ones
);
  // Highest set bit wins; all-zero yields W
  function automatic logic [CW-1:0] f_lead(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = CW'(W);
    for (int i = 0; i < W; i++)
      if (v[i]) n = CW'(W - 1 - i);
    return n;
  endfunction

  // Lowest set bit wins; all-zero yields W
  function automatic logic [CW-1:0] f_trail(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = CW'(W);
    for (int i = W - 1; i >= 0; i--)
      if (v[i]) n = CW'(i);
    return n;
  endfunction

  function automatic logic [CW-1:0] f_ones(input logic [W-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++)
      n = n + CW'(v[i]);
    return n;
  endfunction

  assign lead_zeros  = f_lead(din);
  assign trail_zeros = f_trail(din);
  assign ones        = f_ones(din);
endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          rot_right,
  output logic [W-1:0]  dout
);
  // A right rotation is a left rotation by the two's complement amount (W is a power of two)
  logic [SW-1:0] amt_left;
  logic [W-1:0]  stage [0:SW];

  assign amt_left = rot_right ? (~amt + {{(SW-1){1'b0}}, 1'b1}) : amt;
  assign stage[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stage[s+1] = amt_left[s] ? {stage[s][W-1-K:0], stage[s][W-1:W-K]}
                                    : stage[s];
  end

  assign dout = stage[SW];
endmodule

// File: rtl/bmu_bytes.sv
module bmu_bytes #(
  parameter int W  = 64,
  parameter int NB = W / 8
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] or_comb,
  output logic [W-1:0] swapped
);
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign or_comb[8*i +: 8] = {8{|din[8*i +: 8]}};
    assign swapped[8*i +: 8] = din[8*(NB-1-i) +: 8];
  end
endmodule

// File: rtl/bmu_exec.sv
module bmu_exec
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic            word_mode,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] result
);
  localparam int SW  = $clog2(XLEN);
  localparam int CW  = SW + 1;
  localparam int WCW = 6;

  bmu_op_e op;
  logic    word_active;
  logic    lt_signed, lt_unsigned;

  logic [CW-1:0]   lead_f, trail_f, ones_f;
  logic [XLEN-1:0] rot_f, orc_f, rev_f;
  logic [XLEN-1:0] word_ext;

  assign op          = bmu_op_e'(op_sel);
  assign word_active = (XLEN == 64) && word_mode && has_word_form(op);
  assign lt_signed   = $signed(src_a) < $signed(src_b);
  assign lt_unsigned = src_a < src_b;

  bmu_count #(.W(XLEN)) u_cnt (
    .din(src_a), .lead_zeros(lead_f), .trail_zeros(trail_f), .ones(ones_f)
  );

  bmu_rotate #(.W(XLEN)) u_rot (
    .din(src_a), .amt(src_b[SW-1:0]), .rot_right(op == BM_ROR), .dout(rot_f)
  );

  bmu_bytes #(.W(XLEN)) u_bytes (
    .din(src_a), .or_comb(orc_f), .swapped(rev_f)
  );

  if (XLEN == 64) begin : g_word
    logic [WCW-1:0] lead_w, trail_w, ones_w;
    logic [31:0]    rot_w, word_raw;

    bmu_count #(.W(32)) u_cnt_w (
      .din(src_a[31:0]), .lead_zeros(lead_w), .trail_zeros(trail_w), .ones(ones_w)
    );

    bmu_rotate #(.W(32)) u_rot_w (
      .din(src_a[31:0]), .amt(src_b[4:0]), .rot_right(op == BM_ROR), .dout(rot_w)
    );

    always_comb begin
      unique case (op)
        BM_CLZ:  word_raw = {{(32-WCW){1'b0}}, lead_w};
        BM_CTZ:  word_raw = {{(32-WCW){1'b0}}, trail_w};
        BM_CPOP: word_raw = {{(32-WCW){1'b0}}, ones_w};
        default: word_raw = rot_w;
      endcase
    end

    assign word_ext = {{(XLEN-32){word_raw[31]}}, word_raw};
  end else begin : g_noword
    assign word_ext = '0;
  end

  always_comb begin
    if (word_active) begin
      result = word_ext;
    end else begin
      unique case (op)
        BM_ANDN:  result = src_a & ~src_b;
        BM_ORN:   result = src_a | ~src_b;
        BM_XNOR:  result = ~(src_a ^ src_b);
        BM_CLZ:   result = {{(XLEN-CW){1'b0}}, lead_f};
        BM_CTZ:   result = {{(XLEN-CW){1'b0}}, trail_f};
        BM_CPOP:  result = {{(XLEN-CW){1'b0}}, ones_f};
        BM_MIN:   result = lt_signed   ? src_a : src_b;
        BM_MAX:   result = lt_signed   ? src_b : src_a;
        BM_MINU:  result = lt_unsigned ? src_a : src_b;
        BM_MAXU:  result = lt_unsigned ? src_b : src_a;
        BM_SEXTB: result = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
        BM_SEXTH: result = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
        BM_ZEXTH: result = {{(XLEN-16){1'b0}}, src_a[15:0]};
        BM_ROL,
        BM_ROR:   result = rot_f;
        BM_ORCB:  result = orc_f;
        BM_REV8:  result = rev_f;
        default:  result = '0;
      endcase
    end
  end
endmodule

// File: rtl/bmu_exec_chk.sv
module bmu_exec_chk
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic [OP_W-1:0] op_sel,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic [XLEN-1:0] result,
  input logic            word_active
);
  localparam int NB = XLEN / 8;

  always_comb begin
    if (op_sel == BM_CLZ && !word_active && src_a == '0)
      AST_CLZ_ZERO_WIDTH: assert (result == XLEN) else $error("clz of zero"); // R2

    if (op_sel == BM_MIN || op_sel == BM_MAX || op_sel == BM_MINU || op_sel == BM_MAXU)
      AST_MINMAX_PICKS_OPERAND: assert (result == src_a || result == src_b) else $error("minmax"); // R4

    if ((op_sel == BM_ROL || op_sel == BM_ROR) && !word_active)
      AST_ROT_KEEPS_ONES: assert ($countones(result) == $countones(src_a)) else $error("rotate"); // R7

    if (word_active)
      AST_WORD_SIGN_EXT: assert (result[XLEN-1:31] == '0 || result[XLEN-1:31] == '1) else $error("word sext"); // R10

    if (op_sel == BM_ORCB)
      for (int i = 0; i < NB; i++)
        AST_ORCB_SATURATES: assert (result[8*i +: 8] == (src_a[8*i +: 8] != 0 ? 8'hFF : 8'h00)) else $error("orcb"); // R8

    if (op_sel > BM_REV8)
      AST_UNUSED_CODE_ZERO: assert (result == '0) else $error("unused code"); // R12
  end
endmodule

bind bmu_exec bmu_exec_chk #(.XLEN(XLEN)) u_chk (
  .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .result(result), .word_active(word_active)
);

// File: tb/sim_bmu_exec.sv
module sim_bmu_exec;
  localparam int XLEN       = 64;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      op_sel = '0;
  logic            word_mode = 1'b0;
  logic [XLEN-1:0] src_a = '0, src_b = '0;
  logic [XLEN-1:0] result;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmu_exec #(.XLEN(XLEN)) u0 (
    .op_sel(op_sel), .word_mode(word_mode), .src_a(src_a), .src_b(src_b), .result(result)
  );

  // Independent reference: scan-with-flag counters, concatenation rotates
  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic int cnt_lead(input logic [63:0] v, input int w);
    int n = 0; bit hit = 0;
    for (int i = w - 1; i >= 0; i--) begin
      if (v[i]) hit = 1;
      if (!hit) n++;
    end
    return n;
  endfunction

  function automatic int cnt_trail(input logic [63:0] v, input int w);
    int n = 0; bit hit = 0;
    for (int i = 0; i < w; i++) begin
      if (v[i]) hit = 1;
      if (!hit) n++;
    end
    return n;
  endfunction

  function automatic int cnt_ones(input logic [63:0] v, input int w);
    int n = 0;
    for (int i = 0; i < w; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic [63:0] ref_model(input logic [4:0] op, input bit w,
                                            input logic [63:0] a, input logic [63:0] b);
    logic [127:0] dbl;
    logic [63:0]  dw;
    logic [31:0]  lo;
    lo = a[31:0];
    if (w && (op == 3 || op == 4 || op == 5 || op == 13 || op == 14)) begin
      dw = {lo, lo};
      case (op)
        3:  return sx32(32'(cnt_lead(a, 32)));
        4:  return sx32(32'(cnt_trail(a, 32)));
        5:  return sx32(32'(cnt_ones(a, 32)));
        13: begin dw = dw << b[4:0]; return sx32(dw[63:32]); end
        default: begin dw = dw >> b[4:0]; return sx32(dw[31:0]); end
      endcase
    end
    dbl = {a, a};
    case (op)
      0:  return a & ~b;
      1:  return a | ~b;
      2:  return ~(a ^ b);
      3:  return 64'(cnt_lead(a, 64));
      4:  return 64'(cnt_trail(a, 64));
      5:  return 64'(cnt_ones(a, 64));
      6:  return ($signed(a) <= $signed(b)) ? a : b;
      7:  return ($signed(a) >= $signed(b)) ? a : b;
      8:  return (a <= b) ? a : b;
      9:  return (a >= b) ? a : b;
      10: return 64'($signed(a[7:0]));
      11: return 64'($signed(a[15:0]));
      12: return {48'h0, a[15:0]};
      13: begin dbl = dbl << b[5:0]; return dbl[127:64]; end
      14: begin dbl = dbl >> b[5:0]; return dbl[63:0]; end
      15: begin
            logic [63:0] r = '0;
            for (int k = 0; k < 8; k++) if (a[8*k +: 8] != 0) r[8*k +: 8] = 8'hFF;
            return r;
          end
      16: begin
            logic [63:0] r;
            for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
            return r;
          end
      default: return '0;
    endcase
  endfunction

  // Inputs change after a rising edge; the combinational result is read at the falling edge (R13)
  task automatic chk(input logic [4:0] op, input bit w, input logic [63:0] a,
                     input logic [63:0] b, input logic [63:0] exp, input string req);
    @(posedge clk); #1;
    op_sel = op; word_mode = w; src_a = a; src_b = b;
    @(negedge clk);
    n_vec++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d w=%0b a=%h b=%h actual=%h expected=%h", req, op, w, a, b, result, exp);
    end
  endtask

  task automatic chk_ref(input logic [4:0] op, input bit w, input logic [63:0] a,
                         input logic [63:0] b, input string req);
    chk(op, w, a, b, ref_model(op, w, a, b), req);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    n_vec++;
    if (result !== 64'h0) begin
      n_bad++;
      $display("FAIL R1 idle actual=%h expected=%h", result, 64'h0);
    end
  endtask

  task automatic t_logic;
    chk(0, 0, 64'hF0F0_F0F0_1234_5678, 64'hFF00_FF00_0000_FFFF, 64'h00F0_00F0_1234_0000, "R1 andn");
    chk(1, 0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FF00, 64'h0000_0000_0000_00FF, "R1 orn");
    chk(2, 0, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFFF_0000_0000, "R1 xnor");
  endtask

  task automatic t_count;
    chk(3, 0, 64'h0, 64'h0, 64'd64, "R2 clz zero");
    chk(4, 0, 64'h0, 64'h0, 64'd64, "R2 ctz zero");
    chk(3, 0, 64'h1, 64'h0, 64'd63, "R2 clz one");
    chk(4, 0, 64'h8000_0000_0000_0000, 64'h0, 64'd63, "R2 ctz top");
    chk(3, 0, 64'h8000_0000_0000_0000, 64'h0, 64'd0, "R2 clz top");
    chk_ref(4, 0, 64'h0000_1000_0000_0000, 64'h0, "R2 ctz mid");
    chk(5, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'd64, "R3 cpop ones");
    chk_ref(5, 0, 64'h1234_5678_9ABC_DEF0, 64'h0, "R3 cpop mix");
  endtask

  task automatic t_minmax;
    chk(6, 0, '1, 64'h1, '1,    "R4 min");
    chk(7, 0, '1, 64'h1, 64'h1, "R4 max");
    chk(6, 0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R4 min extreme");
    chk(8, 0, '1, 64'h1, 64'h1, "R5 minu");
    chk(9, 0, '1, 64'h1, '1,    "R5 maxu");
    chk(9, 0, 64'h55, 64'h55, 64'h55, "R5 maxu equal");
  endtask

  task automatic t_ext;
    chk(10, 0, 64'h1234_0000_0000_0080, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, "R6 sextb neg");
    chk(10, 0, 64'hFFFF_0000_0000_007F, 64'h0, 64'h0000_0000_0000_007F, "R6 sextb pos");
    chk(11, 0, 64'h0000_0000_0001_8000, 64'h0, 64'hFFFF_FFFF_FFFF_8000, "R6 sexth");
    chk(12, 0, 64'hFFFF_FFFF_FFFF_8001, 64'h0, 64'h0000_0000_0000_8001, "R6 zexth");
  endtask

  task automatic t_rot;
    chk(13, 0, 64'hF000_0000_0000_000F, 64'd4,  64'h0000_0000_0000_00FF, "R7 rol 4");
    chk(13, 0, 64'hF000_0000_0000_000F, 64'd68, 64'h0000_0000_0000_00FF, "R7 rol high bits ignored");
    chk(14, 0, 64'h0000_0000_0000_0001, 64'd1,  64'h8000_0000_0000_0000, "R7 ror 1");
    chk(14, 0, 64'h1234_5678_9ABC_DEF0, 64'd0,  64'h1234_5678_9ABC_DEF0, "R7 ror 0");
    chk_ref(14, 0, 64'h1234_5678_9ABC_DEF0, 64'd37, "R7 ror 37");
  endtask

  task automatic t_bytes;
    chk(15, 0, 64'h0001_0000_8000_0100, 64'h0, 64'h00FF_0000_FF00_FF00, "R8 orcb");
    chk(15, 0, 64'h0, 64'h0, 64'h0, "R8 orcb zero");
    chk(16, 0, 64'h0102_0304_0506_0708, 64'h0, 64'h0807_0605_0403_0201, "R9 rev8");
  endtask

  task automatic t_word_count;
    chk(3, 1, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'd32, "R10 clzw zero word");
    chk(4, 1, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'd32, "R10 ctzw zero word");
    chk(3, 1, 64'h0000_0001_0000_0001, 64'h0, 64'd31, "R10 clzw");
    chk(5, 1, 64'hFFFF_0000_0000_000F, 64'h0, 64'd4,  "R10 cpopw");
  endtask

  task automatic t_word_rot;
    chk(13, 1, 64'hFFFF_FFFF_8000_0001, 64'd33, 64'h0000_0000_0000_0003, "R11 rolw");
    chk(14, 1, 64'h0000_0000_0000_0001, 64'd1,  64'hFFFF_FFFF_8000_0000, "R11 rorw sext");
    chk_ref(13, 1, 64'hDEAD_BEEF_1234_5678, 64'd12, "R11 rolw 12");
  endtask

  task automatic t_ignore;
    chk(0,  1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R12 andn word flag");
    chk(16, 1, 64'h0102_0304_0506_0708, 64'h0, 64'h0807_0605_0403_0201, "R12 rev8 word flag");
    chk(10, 1, 64'h0000_0000_0000_0080, 64'h0, 64'hFFFF_FFFF_FFFF_FF80, "R12 sextb word flag");
    chk(20, 0, '1, '1, 64'h0, "R12 unused code");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logic();
    t_count();
    t_minmax();
    t_ext();
    t_rot();
    t_bytes();
    t_word_count();
    t_word_rot();
    t_ignore();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule